// File: doc/BRIEF.md
# Flash Write-Busy Status Responder

This block stands in for the part of a parallel NOR flash that reports progress while an internal byte program or erase is running. A launch input starts an operation. The launch carries the operation type and the byte being written. A busy timer then runs for a number of system clock cycles that depends on the operation type. While the timer runs, every read returns a status byte in place of array data. In that byte, bit 7 tells the host whether the operation is a program or an erase. Bit 6 flips on each read access, so a host can poll for completion by comparing two reads.

When no operation is busy, a read passes through the array byte presented on `rd_array`. The array itself sits outside this block. A completed erase therefore shows FFh only if the surrounding array logic supplies it. The read result is registered and holds between read strobes.

Top module: `wr_status_responder`

## Requirements
- R1: After synchronous reset, `busy` is 0 and `rd_data` is 00h.
- R2: A launch accepted while idle raises `busy` at the next clock edge. `busy` then stays high for exactly the cycle count of that operation type. The type is encoded on `launch_op` as 00 byte program, 01 sector erase, 10 block erase and 11 chip erase, and each type has its own duration parameter of at least 1.
- R3: A launch presented while `busy` is high is ignored. It does not extend the busy time, and it does not change the reported operation type, the latched byte or the bit-6 state.
- R4: During a busy byte program, bit 7 of each read is the complement of bit 7 of the launched byte.
- R5: During a busy erase of any kind, bit 7 of each read is 0.
- R6: Bit 6 is cleared at each accepted launch. During busy, the first read returns 0 in bit 6, and each later read returns the opposite of the one before.
- R7: During busy, bits 5 to 0 of each read are 0.
- R8: When a read strobe arrives while idle, `rd_data` takes the value of `rd_array` at the next edge. A program is therefore followed by true data, and an erase whose array now reads FFh is followed by bit 7 reading 1.
- R9: Without a read strobe, `rd_data` keeps its value even if `rd_array` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Starts an operation when idle |
| launch_op | input | 2 | Operation type: 00 program, 01 sector, 10 block, 11 chip erase |
| launch_data | input | 8 | Byte being programmed |
| rd_stb | input | 1 | Read access strobe, one per read |
| rd_array | input | 8 | Array byte returned when idle |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Registered read result |

## Verification
The assertions check on every cycle the following behaviours: the rise of `busy` after an accepted launch, the one-step countdown and its immunity to new launches, the bit-6 clear and flip, the zero low bits during busy, idle pass-through and the hold between strobes. Some behaviours can only be shown by the bench's scenarios, because they depend on a whole operation. These are the exact busy length of each operation type, the program/erase meaning of bit 7 for specific launched bytes, and the full sequence of status bytes across an ignored mid-operation launch.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } wsr_op_e;

  function automatic logic op_is_erase(input wsr_op_e op);
    return op != OP_PROG;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wsr_busy_timer.sv
module wsr_busy_timer
  import wsr_pkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int BLK_CYC  = 50,
  parameter int CHIP_CYC = 80
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  wsr_op_e op,
  output logic    busy
);
  localparam int MAXD = max2(max2(PROG_CYC, SECT_CYC), max2(BLK_CYC, CHIP_CYC));
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  always_comb begin
    case (op)
      OP_PROG: load_val = CW'(PROG_CYC - 1);
      OP_SECT: load_val = CW'(SECT_CYC - 1);
      OP_BLK:  load_val = CW'(BLK_CYC - 1);
      default: load_val = CW'(CHIP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy) else $error("busy did not rise"); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    busy && cnt != '0 |=> busy && cnt == $past(cnt) - 1'b1) else $error("countdown broken"); // R3
endmodule

// File: rtl/wsr_status_gen.sv
module wsr_status_gen
  import wsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  wsr_op_e    op,
  input  logic       wbit7,
  input  logic       rd_stb,
  input  logic       busy,
  output logic [7:0] status
);
  logic erase_q;
  logic b7_q;
  logic tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_q <= 1'b0;
      b7_q    <= 1'b0;
      tog     <= 1'b0;
    end else if (start) begin
      erase_q <= op_is_erase(op);
      b7_q    <= wbit7;
      tog     <= 1'b0;
    end else if (rd_stb && busy) begin
      tog <= ~tog;
    end
  end

  always_comb begin
    status = 8'h00;
    status[7] = erase_q ? 1'b0 : ~b7_q;
    status[6] = tog;
  end

  AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    start |=> !tog) else $error("toggle not cleared"); // R6
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    rd_stb && busy |=> tog != $past(tog)) else $error("toggle did not flip"); // R6
endmodule

// File: rtl/wr_status_responder.sv
module wr_status_responder
  import wsr_pkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int BLK_CYC  = 50,
  parameter int CHIP_CYC = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       launch_valid,
  input  logic [1:0] launch_op,
  input  logic [7:0] launch_data,
  input  logic       rd_stb,
  input  logic [7:0] rd_array,
  output logic       busy,
  output logic [7:0] rd_data
);
  logic       accept;
  logic [7:0] status;
  wsr_op_e    op_in;

  assign op_in  = wsr_op_e'(launch_op);
  assign accept = launch_valid && !busy;

  wsr_busy_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .BLK_CYC(BLK_CYC),   .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start(accept), .op(op_in), .busy(busy)
  );

  wsr_status_gen u_status (
    .clk(clk), .rst(rst), .start(accept), .op(op_in),
    .wbit7(launch_data[7]), .rd_stb(rd_stb), .busy(busy), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= 8'h00;
    else if (rd_stb) rd_data <= busy ? status : rd_array;
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data)) else $error("rd_data changed"); // R9
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_stb && busy |=> rd_data[5:0] == 6'd0) else $error("low bits set"); // R7
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    rd_stb && !busy |=> rd_data == $past(rd_array)) else $error("idle read wrong"); // R8
endmodule

// File: tb/test_wr_status_responder.sv
module test_wr_status_responder;
  localparam int P_CYC = 20, S_CYC = 40, B_CYC = 50, C_CYC = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic launch_valid = 1'b0;
  logic [1:0] launch_op = 2'd0;
  logic [7:0] launch_data = 8'h00;
  logic rd_stb = 1'b0;
  logic [7:0] rd_array = 8'h00;
  logic busy;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  wr_status_responder #(.PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .BLK_CYC(B_CYC), .CHIP_CYC(C_CYC))
    i_wr_status_responder (.clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_op(launch_op),
      .launch_data(launch_data), .rd_stb(rd_stb), .rd_array(rd_array), .busy(busy), .rd_data(rd_data));

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic pend = 1'b0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd_stb;
  always @(negedge clk) if (pend) begin
    item_t it;
    if (sb.size() == 0) check("scoreboard underflow", 1, 0);
    else begin
      it = sb.pop_front();
      check(it.tag, rd_data, it.v);
    end
  end

  task automatic do_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_stb = 1'b1;
    sb.push_back('{v: exp, tag: tag});
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic do_launch(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    launch_valid = 1'b1; launch_op = op; launch_data = d;
    @(negedge clk);
    launch_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 rd_data after reset", rd_data, 0);

    // R4 R6 R7: program with bit7=0 -> status bit7=1
    do_launch(2'b00, 8'h5A);
    do_read(8'h80, "R4 R6 prog read1");
    do_read(8'hC0, "R6 prog read2");
    do_read(8'h80, "R7 prog read3");
    busy_len(n);
    check("R2 program remaining busy", n + 6, P_CYC);
    rd_array = 8'h5A;
    do_read(8'h5A, "R8 true data after program");
    do_read(8'h5A, "R8 bit6 steady after program");

    // R3: ignored launch mid-program
    do_launch(2'b00, 8'h80);
    do_read(8'h00, "R4 prog bit7 complement of 1");
    do_launch(2'b11, 8'h00);
    do_read(8'h40, "R3 ignored launch keeps state");
    busy_len(n);
    check("R3 busy not extended", n + 6, P_CYC);

    // R5: sector erase
    do_launch(2'b01, 8'hFF);
    do_read(8'h00, "R5 erase read1");
    do_read(8'h40, "R5 erase read2");
    do_read(8'h00, "R5 erase read3");
    busy_len(n);
    check("R2 sector busy", n + 6, S_CYC);
    rd_array = 8'hFF;
    do_read(8'hFF, "R8 erased reads FF");

    do_launch(2'b10, 8'h00);
    busy_len(n);
    check("R2 block busy", n, B_CYC);
    do_launch(2'b11, 8'h00);
    do_read(8'h00, "R6 toggle cleared on chip launch");
    busy_len(n);
    check("R2 chip busy", n + 2, C_CYC);

    // R9: hold without strobe
    rd_array = 8'h3C;
    do_read(8'h3C, "R8 idle read");
    rd_array = 8'hA5;
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", rd_data, 8'h3C);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule